// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital register front end of a two-channel, 16-bit converter with a parallel data bus. Each channel keeps two words. A staging word is written from the bus. An output word feeds the converter core. A two-bit channel code picks which channels a strobe acts on: channel A, channel B, both, or neither. Two strobe pins, an active-low write strobe and a load strobe, choose between four actions: staging load, output transfer, pass-through and hold.

An active-low clear pin forces every word to a preset, and it overrides the strobes. A level pin selects the preset, either zero or half scale. The same preset applies when the system reset is active. All pins are registered on the rising edge of the system clock. The action they encode takes effect on the following edge, so an output word moves two edges after the pins change. Each channel also raises a one-cycle update flag in the cycle its output word takes a new value.

Top module: `dual_dac_regif`

## Requirements
- R1: The channel code `chan_sel[1:0]` selects channel A for 2'b00, no channel for 2'b01, both channels for 2'b10 and channel B for 2'b11.
- R2: A sampled `clr_n` of 0 sets both words of both channels to the preset, whatever the strobes and channel code are. The preset is 16'h0000 when the sampled `half_sel` is 0 and 16'h8000 when it is 1.
- R3: While `rst` is high, both words of both channels take the preset chosen by the current `half_sel`, and `upd` is 2'b00.
- R4: With `clr_n`=1, `wr_n`=0 and `ld`=0, the staging word of each selected channel takes `din`, and the output words do not change.
- R5: With `clr_n`=1, `wr_n`=1 and `ld`=1, each selected channel copies its staging word into its output word.
- R6: With `clr_n`=1, `wr_n`=0 and `ld`=1, both words of each selected channel take `din`, so the output follows the bus.
- R7: With `clr_n`=1, `wr_n`=1 and `ld`=0, no word of either channel changes.
- R8: A channel that is not selected keeps both of its words, whatever the strobes are.
- R9: Pins that are present at clock edge k act at edge k+1, and the result is visible on the outputs after edge k+1 and not before.
- R10: `upd[0]` for channel A and `upd[1]` for channel B is 1 for exactly the cycle that follows an edge that changed that channel's output word, and 0 otherwise.
- R11: Suppose both strobes are driven low together for one cycle and then high together for one cycle. The selected outputs then end up holding the bus value of the low cycle, even when the bus has changed by the high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| din | input | 16 | Parallel data bus |
| chan_sel | input | 2 | Channel code |
| wr_n | input | 1 | Write strobe, active low |
| ld | input | 1 | Load strobe |
| clr_n | input | 1 | Clear to preset, active low |
| half_sel | input | 1 | Preset select: 0 zero, 1 half scale |
| dac_a | output | 16 | Channel A output word |
| dac_b | output | 16 | Channel B output word |
| upd | output | 2 | Per-channel output-change flag (bit 0 A, bit 1 B) |

## Verification
A full sweep drives every combination of clear, preset level, write strobe, load strobe and channel code. Between sweep entries the data word changes, so a hold, an output transfer and a pass-through all leave different values, and a channel that is wrongly selected shows up as a moved word. Staging loads are followed by transfers that carry a different bus value, which separates the staging word from the bus. The paired low-then-high strobe sequence shows that the captured value is the one from the low cycle. Repeated identical writes check that the update flag fires only on a real change.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

    localparam int DAC_W  = 16;
    localparam int NCH    = 2;
    localparam int SEL_W  = 2;

    typedef logic [DAC_W-1:0] word_t;
    typedef logic [NCH-1:0]   chmask_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STAGE,
        OP_XFER,
        OP_PASS,
        OP_CLEAR
    } op_e;

    typedef struct packed {
        logic              clr_n;
        logic              half;
        logic              wr_n;
        logic              ld;
        logic [SEL_W-1:0]  chan;
        word_t             data;
    } pins_t;

    localparam pins_t PINS_IDLE = '{clr_n: 1'b1, half: 1'b0, wr_n: 1'b1,
                                    ld: 1'b0, chan: '0, data: '0};

    function automatic word_t preset_word(input logic half);
        word_t w;
        w = '0;
        if (half) w[DAC_W-1] = 1'b1;
        return w;
    endfunction

    function automatic chmask_t chan_mask(input logic [SEL_W-1:0] code);
        chmask_t m;
        case (code)
            2'b00:   m = 2'b01;
            2'b01:   m = 2'b00;
            2'b10:   m = 2'b11;
            default: m = 2'b10;
        endcase
        return m;
    endfunction

    function automatic op_e strobe_op(input logic clr_n, input logic wr_n, input logic ld);
        op_e o;
        if (!clr_n)            o = OP_CLEAR;
        else if (!wr_n && !ld) o = OP_STAGE;
        else if ( wr_n &&  ld) o = OP_XFER;
        else if (!wr_n &&  ld) o = OP_PASS;
        else                   o = OP_HOLD;
        return o;
    endfunction

endpackage

// File: rtl/dac_pin_sampler.sv
module dac_pin_sampler
    import dac_regif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_d,
    output pins_t pins_q
);

    always_ff @(posedge clk) begin
        if (rst) pins_q <= PINS_IDLE;
        else     pins_q <= pins_d;
    end

endmodule

// File: rtl/dac_op_decode.sv
module dac_op_decode
    import dac_regif_pkg::*;
(
    input  pins_t   smp,
    output op_e     op,
    output chmask_t sel,
    output word_t   clr_val
);

    always_comb begin
        op      = strobe_op(smp.clr_n, smp.wr_n, smp.ld);
        sel     = chan_mask(smp.chan);
        clr_val = preset_word(smp.half);
    end

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
    import dac_regif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t init_val,
    input  op_e   op,
    input  logic  sel,
    input  word_t data,
    input  word_t clr_val,
    output word_t stage_q,
    output word_t out_q,
    output logic  upd_q
);

    word_t stage_d;
    word_t out_d;

    always_comb begin
        stage_d = stage_q;
        out_d   = out_q;
        case (op)
            OP_CLEAR: begin
                stage_d = clr_val;
                out_d   = clr_val;
            end
            OP_STAGE: if (sel) stage_d = data;
            OP_XFER:  if (sel) out_d   = stage_q;
            OP_PASS: if (sel) begin
                stage_d = data;
                out_d   = data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= init_val;
            out_q   <= init_val;
            upd_q   <= 1'b0;
        end else begin
            stage_q <= stage_d;
            out_q   <= out_d;
            upd_q   <= (out_d != out_q);
        end
    end

endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
    import dac_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] din,
    input  logic [1:0]  chan_sel,
    input  logic        wr_n,
    input  logic        ld,
    input  logic        clr_n,
    input  logic        half_sel,
    output logic [15:0] dac_a,
    output logic [15:0] dac_b,
    output logic [1:0]  upd
);

    pins_t   pins_raw;
    pins_t   pins_s;
    op_e     op;
    chmask_t sel;
    word_t   clr_val;
    word_t   init_val;
    word_t   stage_w [NCH];
    word_t   out_w   [NCH];
    logic    upd_w   [NCH];

    always_comb begin
        pins_raw.clr_n = clr_n;
        pins_raw.half  = half_sel;
        pins_raw.wr_n  = wr_n;
        pins_raw.ld    = ld;
        pins_raw.chan  = chan_sel;
        pins_raw.data  = din;
        init_val       = preset_word(half_sel);
    end

    dac_pin_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .pins_d (pins_raw),
        .pins_q (pins_s)
    );

    dac_op_decode u_dec (
        .smp     (pins_s),
        .op      (op),
        .sel     (sel),
        .clr_val (clr_val)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dac_chan_regs u_regs (
            .clk      (clk),
            .rst      (rst),
            .init_val (init_val),
            .op       (op),
            .sel      (sel[ch]),
            .data     (pins_s.data),
            .clr_val  (clr_val),
            .stage_q  (stage_w[ch]),
            .out_q    (out_w[ch]),
            .upd_q    (upd_w[ch])
        );
        assign upd[ch] = upd_w[ch];
    end

    assign dac_a = out_w[0];
    assign dac_b = out_w[1];

endmodule

// File: rtl/dual_dac_regif_chk.sv
module dual_dac_regif_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] din,
    input logic [1:0]  chan_sel,
    input logic        wr_n,
    input logic        ld,
    input logic        clr_n,
    input logic        half_sel,
    input logic [15:0] dac_a,
    input logic [15:0] dac_b,
    input logic [1:0]  upd
);

    logic [1:0] live;

    always_ff @(posedge clk) begin
        if (rst)            live <= 2'd0;
        else if (live != 2'd2) live <= live + 2'd1;
    end

    a_r2_clear_preset: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd2 && !$past(clr_n, 2)) |->
        (dac_a == ($past(half_sel, 2) ? 16'h8000 : 16'h0000) &&
         dac_b == ($past(half_sel, 2) ? 16'h8000 : 16'h0000)));

    a_r4_stage_keeps_out: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd2 && $past(clr_n, 2) && !$past(wr_n, 2) && !$past(ld, 2)) |->
        (dac_a == $past(dac_a) && dac_b == $past(dac_b)));

    a_r6_pass_a: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd2 && $past(clr_n, 2) && !$past(wr_n, 2) && $past(ld, 2) &&
         $past(chan_sel, 2) == 2'b00) |-> (dac_a == $past(din, 2)));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd2 && $past(clr_n, 2) && $past(wr_n, 2) && !$past(ld, 2)) |->
        (dac_a == $past(dac_a) && dac_b == $past(dac_b)));

    a_r8_no_channel: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd2 && $past(clr_n, 2) && $past(chan_sel, 2) == 2'b01) |->
        (dac_a == $past(dac_a) && dac_b == $past(dac_b)));

    a_r10_flag_a: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0) |-> (upd[0] == (dac_a != $past(dac_a))));

    a_r10_flag_b: assert property (@(posedge clk) disable iff (rst)
        (live != 2'd0) |-> (upd[1] == (dac_b != $past(dac_b))));

endmodule

bind dual_dac_regif dual_dac_regif_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .chan_sel (chan_sel),
    .wr_n     (wr_n),
    .ld       (ld),
    .clr_n    (clr_n),
    .half_sel (half_sel),
    .dac_a    (dac_a),
    .dac_b    (dac_b),
    .upd      (upd)
);

// File: tb/tb_dual_dac_regif.sv
module tb_dual_dac_regif;
    import dac_regif_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] din = '0;
    logic [1:0]  chan_sel = '0;
    logic        wr_n = 1'b1;
    logic        ld = 1'b0;
    logic        clr_n = 1'b1;
    logic        half_sel = 1'b0;
    logic [15:0] dac_a;
    logic [15:0] dac_b;
    logic [1:0]  upd;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] m_stage [2];
    logic [15:0] m_out   [2];
    pins_t d1, d2;
    string t1, t2;

    always #2.5 clk = ~clk;

    dual_dac_regif dut (
        .clk(clk), .rst(rst), .din(din), .chan_sel(chan_sel), .wr_n(wr_n),
        .ld(ld), .clr_n(clr_n), .half_sel(half_sel),
        .dac_a(dac_a), .dac_b(dac_b), .upd(upd)
    );

    task automatic check16(input string tag, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] bench_mask(input logic [1:0] c);
        if (c == 2'b00) return 2'b01;
        if (c == 2'b01) return 2'b00;
        if (c == 2'b10) return 2'b11;
        return 2'b10;
    endfunction

    task automatic model_apply(input pins_t p, output logic [1:0] chg);
        logic [1:0] m;
        logic [15:0] prev [2];
        m = bench_mask(p.chan);
        for (int c = 0; c < 2; c++) prev[c] = m_out[c];
        for (int c = 0; c < 2; c++) begin
            if (!p.clr_n) begin
                m_stage[c] = p.half ? 16'h8000 : 16'h0000;
                m_out[c]   = p.half ? 16'h8000 : 16'h0000;
            end else if (m[c]) begin
                if (!p.wr_n && !p.ld) m_stage[c] = p.data;
                else if (p.wr_n && p.ld) m_out[c] = m_stage[c];
                else if (!p.wr_n && p.ld) begin
                    m_stage[c] = p.data;
                    m_out[c]   = p.data;
                end
            end
        end
        for (int c = 0; c < 2; c++) chg[c] = (m_out[c] != prev[c]);
    endtask

    task automatic step(input pins_t s, input string tag);
        logic [1:0] chg;
        @(negedge clk);
        model_apply(d2, chg);
        check16(t2, "dac_a", dac_a, m_out[0]);
        check16(t2, "dac_b", dac_b, m_out[1]);
        check16({t2, " R10"}, "upd", {14'd0, upd}, {14'd0, chg});
        d2 = d1; t2 = t1;
        d1 = s;  t1 = tag;
        clr_n = s.clr_n; half_sel = s.half; wr_n = s.wr_n;
        ld = s.ld; chan_sel = s.chan; din = s.data;
    endtask

    function automatic pins_t mk(input logic cn, input logic h, input logic w,
                                 input logic l, input logic [1:0] c,
                                 input logic [15:0] d);
        pins_t p;
        p.clr_n = cn; p.half = h; p.wr_n = w; p.ld = l; p.chan = c; p.data = d;
        return p;
    endfunction

    function automatic string op_tag(input pins_t p);
        if (!p.clr_n) return "R2";
        if (p.chan == 2'b01) return "R8";
        if (!p.wr_n && !p.ld) return "R4 R1";
        if (p.wr_n && p.ld) return "R5 R1";
        if (!p.wr_n && p.ld) return "R6 R1";
        return "R7";
    endfunction

    task automatic do_reset(input logic h);
        @(negedge clk);
        rst = 1'b1; clr_n = 1'b1; half_sel = h; wr_n = 1'b1; ld = 1'b0;
        chan_sel = 2'b00; din = 16'h0;
        repeat (3) @(negedge clk);
        // R3: preset while reset is held
        check16("R3", "dac_a", dac_a, h ? 16'h8000 : 16'h0000);
        check16("R3", "dac_b", dac_b, h ? 16'h8000 : 16'h0000);
        check16("R3", "upd", {14'd0, upd}, 16'd0);
        rst = 1'b0;
        for (int c = 0; c < 2; c++) begin
            m_stage[c] = h ? 16'h8000 : 16'h0000;
            m_out[c]   = h ? 16'h8000 : 16'h0000;
        end
        d1 = mk(1, h, 1, 0, 2'b00, 16'h0); t1 = "R7";
        d2 = d1; t2 = t1;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        do_reset(1'b0);

        // R1 / R4 / R5: stage per channel code, then transfer with a different bus
        step(mk(1, 0, 0, 0, 2'b00, 16'h1111), "R4 R1");
        step(mk(1, 0, 0, 0, 2'b11, 16'h2222), "R4 R1");
        step(mk(1, 0, 1, 0, 2'b00, 16'hdead), "R7");
        step(mk(1, 0, 1, 1, 2'b10, 16'hbeef), "R5 R1");
        step(mk(1, 0, 1, 0, 2'b10, 16'h0f0f), "R7");
        step(mk(1, 0, 1, 0, 2'b10, 16'h0f0f), "R7");

        // R9: pass-through held one cycle; outputs change only after two edges
        step(mk(1, 0, 0, 1, 2'b00, 16'h4321), "R9 R6");
        step(mk(1, 0, 1, 0, 2'b00, 16'h0000), "R9");
        step(mk(1, 0, 1, 0, 2'b00, 16'h0000), "R9");

        // R10: rewriting the same value raises no flag
        step(mk(1, 0, 0, 1, 2'b00, 16'h4321), "R10");
        step(mk(1, 0, 0, 1, 2'b00, 16'h4321), "R10");

        // R11: strobes tied, low then high, bus changes in the high cycle
        step(mk(1, 0, 0, 0, 2'b10, 16'h7a5c), "R11");
        step(mk(1, 0, 1, 1, 2'b10, 16'h0001), "R11");
        step(mk(1, 0, 1, 0, 2'b10, 16'h0002), "R11");
        step(mk(1, 0, 1, 0, 2'b10, 16'h0002), "R11");

        // R2: clear overrides every strobe combination
        step(mk(0, 1, 0, 1, 2'b10, 16'h5555), "R2");
        step(mk(0, 0, 1, 1, 2'b01, 16'h5555), "R2");

        // Full sweep of clear, level, strobes and channel code
        for (int cn = 0; cn < 2; cn++)
            for (int h = 0; h < 2; h++)
                for (int w = 0; w < 2; w++)
                    for (int l = 0; l < 2; l++)
                        for (int c = 0; c < 4; c++) begin
                            pins_t p;
                            logic [15:0] dv;
                            dv = 16'((cn * 32 + h * 16 + w * 8 + l * 4 + c + 1) * 16'h0b3d);
                            step(mk(1, 0, 0, 0, 2'b10, dv ^ 16'hffff), "R4 R1");
                            p = mk(cn[0], h[0], w[0], l[0], c[1:0], dv);
                            step(p, op_tag(p));
                            step(mk(1, 0, 1, 0, 2'b00, 16'h0), "R7");
                        end

        // drain the pipeline
        step(mk(1, 0, 1, 0, 2'b00, 16'h0), "R7");
        step(mk(1, 0, 1, 0, 2'b00, 16'h0), "R7");
        step(mk(1, 0, 1, 0, 2'b00, 16'h0), "R7");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule